// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is the boundary register of a test access port. It sits between the functional core and the I/O pads. There is one cell per input pin and one per output pin. Output enables are not scanned per pin: pins are grouped, and one control cell sets the enable for a whole group of up to `OE_GROUP` (default 3) output pads. Each cell has a capture/shift flip-flop clocked on the rising edge of `tck`. It also has an update stage loaded on the falling edge of `tck`. The update stage holds the value the cell presents to the pins while a test is running.

The surrounding TAP controller supplies the Test-Logic-Reset flag, the data-register select, the capture, shift and update strobes, and a decoded instruction mode. The mode selects where the pads and the core inputs take their values:
- **Functional and SAMPLE:** everything passes through untouched.
- **EXTEST and CLAMP:** pads are driven from the update stages.
- **INTEST:** the update stages also drive the core inputs, and the core clock is switched to `tck`.
- **HIGHZ:** every output enable is released.

Supply and ground pins are not ports of this block and carry no cell. The order of cells between `tdi` and `tdo` comes from a parameter. The data path has no back-pressure: one bit moves per shift cycle, and there is no valid/ready handshake.

Top module: `bscan_chain`

## Requirements
- R1: The chain holds exactly `N_IN + N_OUT + ceil(N_OUT/OE_GROUP)` cells. Cell indices run as follows: inputs first (0..N_IN-1), then outputs, then control cells. Control cell g governs output pins g*OE_GROUP up to g*OE_GROUP+OE_GROUP-1.
- R2: On a rising `tck` with `dr_sel` and `capture_dr` high, each cell captures its parallel value. Input cells take `pin_in`, output cells take `core_out`, and a control cell takes the OR of `core_oe` over its group. Capture has priority over shift.
- R3: On a rising `tck` with `dr_sel` and `shift_dr` high, every cell loads the value of its neighbour one position nearer to `tdi`. Position 0 loads `tdi`. `tdo` always shows the cell at the last position.
- R4: When `ORDER_MAP` is zero, chain position p (counted from `tdi`) holds cell p. Otherwise position p holds the cell whose index is stored in `ORDER_MAP[8p+7:8p]`.
- R5: Update stages load from the capture flip-flops only on a falling `tck` with `dr_sel` and `update_dr` high. Capturing and shifting leave the pins untouched.
- R6: While `tlr` is high, the update stages and capture flip-flops are cleared. The safe state is all pads disabled with data 0, and INTEST core inputs at 0.
- R7: In functional mode (`mode_i` = 0, or any code above 5) and in SAMPLE (1), `pad_out` = `core_out`, `pad_oe` = `core_oe` and `core_in` = `pin_in`.
- R8: In EXTEST (2) and CLAMP (4), `pad_out` comes from the output update stages. Each `pad_oe[j]` comes from the update stage of control cell j/OE_GROUP.
- R9: In HIGHZ (5), all `pad_oe` bits are 0 regardless of the update stages.
- R10: In INTEST (3), pads are driven as in R8, `core_in` comes from the input update stages, and `core_clk` follows `tck`. In every other mode `core_clk` follows `sys_clk` and `core_in` follows `pin_in`.
- R11: With `dr_sel` low, the capture, shift and update strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr | input | 1 | TAP in Test-Logic-Reset, active high |
| sys_clk | input | 1 | Functional core clock from the pad |
| mode_i | input | 3 | Decoded instruction mode |
| dr_sel | input | 1 | Boundary register selected as data register |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| pin_in | input | N_IN | Values arriving from input pads |
| core_in | output | N_IN | Values delivered to the core inputs |
| core_out | input | N_OUT | Core output data |
| core_oe | input | N_OUT | Core output enables |
| pad_out | output | N_OUT | Data to output pads |
| pad_oe | output | N_OUT | Enables to output pads |
| core_clk | output | 1 | Clock delivered to the core |

## Verification
The case hardest to reach from the ports is a shared control cell holding a different value from its neighbour. The check must show that every pad in the group follows that one cell, and that the mapping survives a permuted chain order. To reach it, the stimulus sweeps every combination of output and control values through a full shift and update, on two instances: one with a scrambled order map and one with the default order. The bench then reads the chain back to confirm that the shifted data arrived at the positions the map predicts. Strobes issued while the register is deselected are checked by loading a known pattern first, pulsing every strobe with the register deselected, and then showing that both the pads and the read-back are unchanged.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [2:0] {
    BSM_FUNC   = 3'd0,
    BSM_SAMPLE = 3'd1,
    BSM_EXTEST = 3'd2,
    BSM_INTEST = 3'd3,
    BSM_CLAMP  = 3'd4,
    BSM_HIGHZ  = 3'd5
  } bsm_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/bsc_cell.sv
module bsc_cell (
  input  logic tck,
  input  logic tlr,
  input  logic cap_en,
  input  logic shf_en,
  input  logic upd_en,
  input  logic par_i,
  input  logic ser_i,
  output logic cap_q,
  output logic upd_q
);
  always_ff @(posedge tck) begin
    if (tlr)         cap_q <= 1'b0;
    else if (cap_en) cap_q <= par_i;
    else if (shf_en) cap_q <= ser_i;
  end

  always_ff @(negedge tck) begin
    if (tlr)         upd_q <= 1'b0;
    else if (upd_en) upd_q <= cap_q;
  end

  // R3
  shift_step_chk: assert property (@(posedge tck) disable iff (tlr)
    (shf_en && !cap_en) |=> (cap_q == $past(ser_i)));

  // R5
  upd_hold_chk: assert property (@(negedge tck) disable iff (tlr)
    !upd_en |=> $stable(upd_q));
endmodule

// File: rtl/bsc_order.sv
module bsc_order #(
  parameter int          LEN       = 9,
  parameter logic [255:0] ORDER_MAP = '0
) (
  input  logic           tdi,
  input  logic [LEN-1:0] cap,
  output logic [LEN-1:0] ser_in,
  output logic           tdo
);
  localparam bit USE_MAP = (ORDER_MAP != '0);

  function automatic int cell_of(input int p);
    if (USE_MAP) return int'(ORDER_MAP[p*8 +: 8]);
    else         return p;
  endfunction

  always_comb begin
    ser_in = '0;
    for (int p = 0; p < LEN; p++) begin
      if (p == 0) ser_in[cell_of(0)] = tdi;
      else        ser_in[cell_of(p)] = cap[cell_of(p-1)];
    end
  end

  assign tdo = cap[cell_of(LEN-1)];
endmodule

// File: rtl/bsc_pinmux.sv
module bsc_pinmux
  import bsc_pkg::*;
#(
  parameter int N_IN     = 3,
  parameter int N_OUT    = 4,
  parameter int OE_GROUP = 3,
  localparam int N_CTL   = ceil_div(N_OUT, OE_GROUP)
) (
  input  logic             tck,
  input  logic             tlr,
  input  logic             sys_clk,
  input  bsm_e             mode,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  input  logic [N_IN-1:0]  upd_in,
  input  logic [N_OUT-1:0] upd_out,
  input  logic [N_CTL-1:0] upd_ctl,
  output logic [N_IN-1:0]  core_in,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe,
  output logic             core_clk
);
  logic [N_OUT-1:0] ctl_oe;

  for (genvar j = 0; j < N_OUT; j++) begin : g_fan
    assign ctl_oe[j] = upd_ctl[j / OE_GROUP];
  end

  always_comb begin
    core_in  = pin_in;
    pad_out  = core_out;
    pad_oe   = core_oe;
    core_clk = sys_clk;
    case (mode)
      BSM_EXTEST, BSM_CLAMP: begin
        pad_out = upd_out;
        pad_oe  = ctl_oe;
      end
      BSM_INTEST: begin
        pad_out  = upd_out;
        pad_oe   = ctl_oe;
        core_in  = upd_in;
        core_clk = tck;
      end
      BSM_HIGHZ: begin
        pad_out = upd_out;
        pad_oe  = '0;
      end
      default: ;
    endcase
  end

  // R9
  highz_release_chk: assert property (@(posedge tck) disable iff (tlr)
    (mode == BSM_HIGHZ) |-> (pad_oe == '0));

  // R8
  ext_drive_chk: assert property (@(posedge tck) disable iff (tlr)
    (mode == BSM_EXTEST || mode == BSM_CLAMP) |-> (pad_out == upd_out));

  // R7
  func_pass_chk: assert property (@(posedge tck) disable iff (tlr)
    (mode == BSM_FUNC || mode == BSM_SAMPLE) |->
      (pad_out == core_out && pad_oe == core_oe && core_in == pin_in));

  // R10
  intest_in_chk: assert property (@(posedge tck) disable iff (tlr)
    (mode == BSM_INTEST) |-> (core_in == upd_in));
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bsc_pkg::*;
#(
  parameter int           N_IN      = 3,
  parameter int           N_OUT     = 4,
  parameter int           OE_GROUP  = 3,
  parameter logic [255:0] ORDER_MAP = '0
) (
  input  logic             tck,
  input  logic             tlr,
  input  logic             sys_clk,
  input  logic [2:0]       mode_i,
  input  logic             dr_sel,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  output logic             tdo,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe,
  output logic             core_clk
);
  localparam int N_CTL = ceil_div(N_OUT, OE_GROUP);
  localparam int LEN   = N_IN + N_OUT + N_CTL;

  bsm_e           mode;
  logic [LEN-1:0] par, cap, upd, ser_in;
  logic [N_CTL-1:0] grp_oe;
  logic cap_en, shf_en, upd_en;

  assign mode   = bsm_e'(mode_i);
  assign cap_en = dr_sel & capture_dr;
  assign shf_en = dr_sel & shift_dr;
  assign upd_en = dr_sel & update_dr;

  always_comb begin
    for (int g = 0; g < N_CTL; g++) begin
      grp_oe[g] = 1'b0;
      for (int k = 0; k < OE_GROUP; k++)
        if (g*OE_GROUP + k < N_OUT) grp_oe[g] = grp_oe[g] | core_oe[g*OE_GROUP + k];
    end
  end

  assign par = {grp_oe, core_out, pin_in};

  for (genvar c = 0; c < LEN; c++) begin : g_cell
    bsc_cell u_cell (
      .tck(tck), .tlr(tlr), .cap_en(cap_en), .shf_en(shf_en), .upd_en(upd_en),
      .par_i(par[c]), .ser_i(ser_in[c]), .cap_q(cap[c]), .upd_q(upd[c])
    );
  end

  bsc_order #(.LEN(LEN), .ORDER_MAP(ORDER_MAP)) u_order (
    .tdi(tdi), .cap(cap), .ser_in(ser_in), .tdo(tdo)
  );

  bsc_pinmux #(.N_IN(N_IN), .N_OUT(N_OUT), .OE_GROUP(OE_GROUP)) u_mux (
    .tck(tck), .tlr(tlr), .sys_clk(sys_clk), .mode(mode),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .upd_in(upd[N_IN-1:0]), .upd_out(upd[N_IN+N_OUT-1:N_IN]),
    .upd_ctl(upd[LEN-1:N_IN+N_OUT]),
    .core_in(core_in), .pad_out(pad_out), .pad_oe(pad_oe), .core_clk(core_clk)
  );

  // R11
  desel_hold_chk: assert property (@(posedge tck) disable iff (tlr)
    !dr_sel |=> $stable(cap));
endmodule

// File: tb/tb_bscan_chain.sv
`timescale 1ns/1ps
module tb_bscan_chain;
  import bsc_pkg::*;

  localparam int L = 9;
  // position p (from tdi) -> cell index; position 0 is the lowest byte
  localparam logic [255:0] MAP =
    {184'd0, 8'd4, 8'd2, 8'd6, 8'd1, 8'd5, 8'd7, 8'd0, 8'd3, 8'd8};
  int map_c [L] = '{8, 3, 0, 7, 5, 1, 6, 2, 4};

  logic tck = 1'b0, tlr = 1'b1, sys_clk = 1'b0;
  logic [2:0] mode = BSM_FUNC;
  logic dr_sel = 1'b1, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic tdi_a = 1'b0, tdi_b = 1'b0, tdo_a, tdo_b;
  logic [2:0] pin_in = '0;
  logic [3:0] core_out = '0, core_oe = '0;
  logic [2:0] core_in_a, core_in_b;
  logic [3:0] pad_out_a, pad_oe_a, pad_out_b, pad_oe_b;
  logic core_clk_a, core_clk_b;

  int n_chk = 0, n_fail = 0;

  always #10 tck = ~tck;

  bscan_chain #(.ORDER_MAP(MAP)) dut (
    .tck(tck), .tlr(tlr), .sys_clk(sys_clk), .mode_i(mode), .dr_sel(dr_sel),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi_a), .tdo(tdo_a), .pin_in(pin_in), .core_in(core_in_a),
    .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out_a),
    .pad_oe(pad_oe_a), .core_clk(core_clk_a));

  bscan_chain dut_id (
    .tck(tck), .tlr(tlr), .sys_clk(sys_clk), .mode_i(mode), .dr_sel(dr_sel),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi_b), .tdo(tdo_b), .pin_in(pin_in), .core_in(core_in_b),
    .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out_b),
    .pad_oe(pad_oe_b), .core_clk(core_clk_b));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge tck); #1;
  endtask

  task automatic do_capture();
    capture_dr = 1'b1; tick(); capture_dr = 1'b0;
  endtask

  task automatic do_update();
    update_dr = 1'b1; tick(); update_dr = 1'b0;
  endtask

  // loads cellv into both chains, returns previous contents per cell index
  task automatic do_shift(input logic [L-1:0] cellv,
                          output logic [L-1:0] got_a, output logic [L-1:0] got_b);
    shift_dr = 1'b1;
    for (int i = 0; i < L; i++) begin
      tdi_a = cellv[map_c[L-1-i]];
      tdi_b = cellv[L-1-i];
      got_a[map_c[L-1-i]] = tdo_a;
      got_b[L-1-i] = tdo_b;
      tick();
    end
    shift_dr = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [L-1:0] ga, gb, exp, cv;
    logic [3:0] oe_e;

    // reset state (R6)
    mode = BSM_EXTEST;
    tick(); tick();
    check(pad_oe_a == 4'h0 && pad_oe_b == 4'h0, "R6 reset oe", pad_oe_a, 0);
    check(pad_out_a == 4'h0, "R6 reset data", pad_out_a, 0);
    mode = BSM_INTEST; pin_in = 3'b111; #1;
    check(core_in_a == 3'b000, "R6 reset core_in", core_in_a, 0);
    tlr = 1'b0; tick();

    // SAMPLE sweep: capture (R2), order (R4), passthrough (R7)
    mode = BSM_SAMPLE;
    for (int pi = 0; pi < 8; pi++) begin
      for (int co = 0; co < 16; co++) begin
        pin_in = 3'(pi); core_out = 4'(co);
        core_oe = {core_out[0], core_out[3:1]} ^ 4'(pi);
        #1;
        check(pad_out_a == core_out && pad_oe_a == core_oe && core_in_a == pin_in,
              "R7 sample passthrough", {pad_out_a, pad_oe_a}, {core_out, core_oe});
        do_capture();
        do_shift('0, ga, gb);
        exp = {core_oe[3], |core_oe[2:0], core_out, pin_in};
        check(ga == exp, "R2 R4 capture mapped", ga, exp);
        check(gb == exp, "R2 R4 capture default", gb, exp);
      end
    end

    // EXTEST sweep: update (R5), group enables (R8), shift path (R1 R3)
    mode = BSM_EXTEST; core_out = 4'b1010; core_oe = 4'b0101; pin_in = 3'b011;
    for (int v = 0; v < 64; v++) begin
      cv = {v[5:4], v[3:0], v[2:0]};
      do_shift(cv, ga, gb);
      do_update();
      oe_e = {v[5], {3{v[4]}}};
      check(pad_out_a == v[3:0] && pad_oe_a == oe_e, "R8 extest mapped",
            {pad_out_a, pad_oe_a}, {v[3:0], oe_e});
      check(pad_out_b == v[3:0] && pad_oe_b == oe_e, "R8 extest default",
            {pad_out_b, pad_oe_b}, {v[3:0], oe_e});
      check(core_in_a == pin_in, "R10 extest core_in", core_in_a, pin_in);
      do_shift(~cv, ga, gb);
      check(ga == cv && gb == cv, "R1 R3 readback", ga, cv);
      check(pad_out_a == v[3:0] && pad_oe_a == oe_e, "R5 shift keeps pads",
            {pad_out_a, pad_oe_a}, {v[3:0], oe_e});
      do_shift(cv, ga, gb);
    end

    // CLAMP (R8)
    cv = {2'b10, 4'b0110, 3'b000};
    do_shift(cv, ga, gb); do_update();
    mode = BSM_CLAMP; core_out = 4'b0001; #1;
    check(pad_out_a == 4'b0110 && pad_oe_a == 4'b1000, "R8 clamp",
          {pad_out_a, pad_oe_a}, {4'b0110, 4'b1000});

    // HIGHZ (R9)
    cv = {2'b11, 4'b1111, 3'b000};
    do_shift(cv, ga, gb); do_update();
    mode = BSM_HIGHZ; #1;
    check(pad_oe_a == 4'h0 && pad_oe_b == 4'h0, "R9 highz", pad_oe_a, 0);

    // INTEST (R10)
    mode = BSM_INTEST; pin_in = 3'b000;
    for (int k = 0; k < 8; k++) begin
      cv = {2'b01, 4'b0000, 3'(k)};
      do_shift(cv, ga, gb); do_update();
      check(core_in_a == 3'(k) && core_in_b == 3'(k), "R10 intest core_in",
            core_in_a, k);
    end
    check(core_clk_a == 1'b1, "R10 intest clk high", core_clk_a, 1);
    @(negedge tck); #1;
    check(core_clk_a == 1'b0, "R10 intest clk low", core_clk_a, 0);
    @(posedge tck); #1;
    mode = BSM_FUNC; sys_clk = 1'b0; #1;
    check(core_clk_a == 1'b0, "R10 func clk sys low", core_clk_a, 0);
    sys_clk = 1'b1; #1;
    check(core_clk_a == 1'b1 && core_in_a == pin_in, "R10 func clk sys high",
          core_clk_a, 1);
    sys_clk = 1'b0;

    // deselected strobes ignored (R11)
    mode = BSM_EXTEST;
    cv = {2'b10, 4'b1001, 3'b101};
    do_shift(cv, ga, gb); do_update();
    dr_sel = 1'b0; pin_in = 3'b010; core_out = 4'b0110;
    do_capture();
    do_shift(~cv, ga, gb);
    do_update();
    check(pad_out_a == 4'b1001 && pad_oe_a == 4'b1000, "R11 pads held",
          {pad_out_a, pad_oe_a}, {4'b1001, 4'b1000});
    dr_sel = 1'b1;
    do_shift('0, ga, gb);
    check(ga == cv && gb == cv, "R11 chain held", ga, cv);

    // TLR clears update stages (R6)
    cv = {2'b11, 4'b1111, 3'b111};
    do_shift(cv, ga, gb); do_update();
    check(pad_oe_a == 4'hF, "R8 enabled before reset", pad_oe_a, 4'hF);
    tlr = 1'b1; tick(); tlr = 1'b0;
    check(pad_oe_a == 4'h0 && pad_out_a == 4'h0, "R6 tlr safe",
          {pad_out_a, pad_oe_a}, 0);

    // functional passthrough (R7)
    mode = BSM_FUNC; core_out = 4'b1100; core_oe = 4'b0011; #1;
    check(pad_out_a == 4'b1100 && pad_oe_a == 4'b0011, "R7 functional",
          {pad_out_a, pad_oe_a}, {4'b1100, 4'b0011});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule